// File: doc/BRIEF.md
# Compositional Microprogram Sequencer with Address Transformer

This block is a microprogrammed control unit built around an eight-word control store. A program counter addresses the store, and each word drives five microoperation lines together with a continuation flag. A straight run of words that follow one another is called a linear chain. Inside a chain the counter steps to the next address on every clock.

When the word being read has its continuation flag clear, the chain ends. A transition stage then looks at a two-bit chain-code register and at the two logic-condition inputs. It picks the next chain and a one-bit entry code. The entry code matters only for a chain that has more than one entry point.

A separate address transformer turns the pair (next chain code, entry code) into the full three-bit entry address. The counter takes that address on the same clock edge on which the chain register takes the new code. The transition stage therefore never has to produce a whole address: it produces only a chain code and a short entry code.

The microprogram has three chains:

| Chain | Code | Addresses | Entry points |
|---|---|---|---|
| A | 00 | 000 to 100 | 000 and 011 |
| B | 01 | 101 to 110 | 101 |
| C | 10 | 111 | 111 |

Top module: `cmcu_seq_top`

## Requirements
- R1: The reset is synchronous and active-low. A clock edge with `rst_n` low sets the counter to 000 and the chain register to code 00. While the counter is at 000, `y` reads 5'b00011.
- R2: `y` follows the word at the counter with no clock delay. Bit k-1 of `y` is microoperation k. The words by address are: 000→00011, 001→00101, 010→00011, 011→00100, 100→10010, 101→01001, 110→00100, 111→00101.
- R3: Words 000, 001, 010, 011 and 101 carry the continuation flag. After such a word, the counter advances by exactly one on the next edge.
- R4: At the end of chain A (address 100) with `x1`=1, the next address is 101 and the chain register becomes 01.
- R5: At address 100 with `x1`=0 and `x2`=1, the next address is 111 and the chain register becomes 10.
- R6: At address 100 with `x1`=0 and `x2`=0, the unit re-enters chain A at its second entry point. The entry code is 1, the next address is 011, and the chain register stays 00.
- R7: At the end of chain B (address 110), the next address is 111 and the chain code is 10, whatever the inputs are.
- R8: At the end of chain C (address 111), the next address is 101 and the chain code is 01, whatever the inputs are.
- R9: The chain register always holds the code of the chain that contains the counter's address: 00 for 000 to 100, 01 for 101 and 110, 10 for 111. It never holds 11. If it ever holds 11, the transformer sends the unit to 000 and code 00.
- R10: `x1` and `x2` have no effect on any edge other than one where the counter is at 100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| x1 | input | 1 | Logic condition, examined at the end of chain A |
| x2 | input | 1 | Logic condition, examined at the end of chain A when `x1` is 0 |
| y | output | 5 | Microoperation lines; bit k-1 is microoperation k |

## Verification
The bench builds the block with its default parameters:
- a 3-bit address,
- a 2-bit chain code,
- a 1-bit entry code,
- five microoperation lines.

With these values every control-store word can be reached, and so can every chain exit, including the second entry point of chain A that only entry code 1 selects. A stored vector walk and a flowchart model are then run with each of the four condition pairs held for many passes. They compare `y` on every cycle, and they cover the chain exits that ignore the inputs and resets that arrive in the middle of a chain.

// File: rtl/cmcu_pkg.sv
// Package: shared sizes, chain codes and entry addresses for the
// compositional microprogram sequencer.
// Assumes the fixed eight-word microprogram that is described in the brief.
package cmcu_pkg;

    // Counter width; the control store has 2**ADDR_W words.
    localparam int ADDR_W  = 3;
    // Width of the chain-code register.
    localparam int CHAIN_W = 2;
    // Width of the entry code; only the low bit is ever non-zero.
    localparam int ENTRY_W = 1;
    // Number of microoperation lines.
    localparam int MO_W    = 5;
    // Control word width: the microoperations plus the continuation flag.
    localparam int WORD_W  = MO_W + 1;

    // Chain codes.
    localparam logic [CHAIN_W-1:0] CH_A   = 2'b00;
    localparam logic [CHAIN_W-1:0] CH_B   = 2'b01;
    localparam logic [CHAIN_W-1:0] CH_C   = 2'b10;
    localparam logic [CHAIN_W-1:0] CH_BAD = 2'b11;

    // Entry codes.
    localparam logic [ENTRY_W-1:0] ENT_FIRST  = '0;
    localparam logic [ENTRY_W-1:0] ENT_SECOND = ENTRY_W'(1);

    // Entry addresses that the address transformer produces.
    localparam logic [ADDR_W-1:0] A_HEAD  = 3'd0;
    localparam logic [ADDR_W-1:0] A_MID   = 3'd3;
    localparam logic [ADDR_W-1:0] B_HEAD  = 3'd5;
    localparam logic [ADDR_W-1:0] C_HEAD  = 3'd7;

endpackage

// File: rtl/cmcu_ctrl_store.sv
// Control store: a combinational read of the microinstruction at addr_i.
// Word layout is {continuation, mo[MO_W-1:0]}; mo bit k-1 is microoperation k.
// Assumes ADDR_W = 3 and MO_W = 5, which the stored program requires.
module cmcu_ctrl_store #(
    parameter int ADDR_W = cmcu_pkg::ADDR_W,
    parameter int MO_W   = cmcu_pkg::MO_W
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              cont_o,
    output logic [MO_W-1:0]   mo_o
);
    localparam int WORD_W = MO_W + 1;

    logic [WORD_W-1:0] word;

    // Decode the address into the stored word.
    always_comb begin
        case (addr_i)
            3'd0:    word = WORD_W'(6'b1_00011);
            3'd1:    word = WORD_W'(6'b1_00101);
            3'd2:    word = WORD_W'(6'b1_00011);
            3'd3:    word = WORD_W'(6'b1_00100);
            3'd4:    word = WORD_W'(6'b0_10010);
            3'd5:    word = WORD_W'(6'b1_01001);
            3'd6:    word = WORD_W'(6'b0_00100);
            3'd7:    word = WORD_W'(6'b0_00101);
            default: word = '0;
        endcase
    end

    // Split the word into its microoperation lines and the continuation flag.
    for (genvar i = 0; i < MO_W; i++) begin : g_mo
        assign mo_o[i] = word[i];
    end
    assign cont_o = word[WORD_W-1];

endmodule

// File: rtl/cmcu_chain_select.sv
// Transition stage: from the current chain code and the logic conditions,
// selects the next chain and a short entry code. It is used only when a
// chain ends. Assumes that the chains of the brief leave from their last words.
module cmcu_chain_select #(
    parameter int CHAIN_W = cmcu_pkg::CHAIN_W,
    parameter int ENTRY_W = cmcu_pkg::ENTRY_W
) (
    input  logic [CHAIN_W-1:0] chain_i,
    input  logic               x1_i,
    input  logic               x2_i,
    output logic [CHAIN_W-1:0] next_chain_o,
    output logic [ENTRY_W-1:0] entry_o
);
    import cmcu_pkg::*;

    // Next-chain and entry-code selection.
    always_comb begin
        next_chain_o = CH_A;
        entry_o      = ENT_FIRST;
        case (chain_i)
            CH_A: begin
                if (x1_i) begin
                    next_chain_o = CH_B;
                end else if (x2_i) begin
                    next_chain_o = CH_C;
                end else begin
                    next_chain_o = CH_A;
                    entry_o      = ENT_SECOND;
                end
            end
            CH_B:    next_chain_o = CH_C;
            CH_C:    next_chain_o = CH_B;
            default: begin
                next_chain_o = CH_A;
                entry_o      = ENT_FIRST;
            end
        endcase
    end

endmodule

// File: rtl/cmcu_addr_xform.sv
// Address transformer: maps the pair (chain code, entry code) to the full
// entry address of the chain. Only entry bit 0 is examined, because the entry
// codes keep their upper bits at zero. An unused chain code maps to address 0.
module cmcu_addr_xform #(
    parameter int ADDR_W  = cmcu_pkg::ADDR_W,
    parameter int CHAIN_W = cmcu_pkg::CHAIN_W,
    parameter int ENTRY_W = cmcu_pkg::ENTRY_W
) (
    input  logic [CHAIN_W-1:0] chain_i,
    input  logic [ENTRY_W-1:0] entry_i,
    output logic [ADDR_W-1:0]  addr_o
);
    import cmcu_pkg::*;

    // Product terms of the transformer.
    always_comb begin
        case (chain_i)
            CH_A:    addr_o = entry_i[0] ? A_MID : A_HEAD;
            CH_B:    addr_o = B_HEAD;
            CH_C:    addr_o = C_HEAD;
            default: addr_o = A_HEAD;
        endcase
    end

endmodule

// File: rtl/cmcu_seq_top.sv
// Top level of the compositional microprogram sequencer.
// The program counter steps inside a chain. At the end of a chain, the
// counter takes the transformed entry address and the chain register takes
// the new chain code, both on the same edge. The reset is synchronous and
// active-low. The outputs are read combinationally from the control store.
module cmcu_seq_top #(
    parameter int ADDR_W  = cmcu_pkg::ADDR_W,
    parameter int CHAIN_W = cmcu_pkg::CHAIN_W,
    parameter int ENTRY_W = cmcu_pkg::ENTRY_W,
    parameter int MO_W    = cmcu_pkg::MO_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            x1,
    input  logic            x2,
    output logic [MO_W-1:0] y
);
    import cmcu_pkg::*;

    logic [ADDR_W-1:0]  pc_q;
    logic [CHAIN_W-1:0] chain_q;
    logic               cont;
    logic [CHAIN_W-1:0] next_chain;
    logic [ENTRY_W-1:0] entry;
    logic [ADDR_W-1:0]  xf_addr;

    cmcu_ctrl_store #(.ADDR_W(ADDR_W), .MO_W(MO_W)) store_i (
        .addr_i (pc_q),
        .cont_o (cont),
        .mo_o   (y)
    );

    cmcu_chain_select #(.CHAIN_W(CHAIN_W), .ENTRY_W(ENTRY_W)) sel_i (
        .chain_i      (chain_q),
        .x1_i         (x1),
        .x2_i         (x2),
        .next_chain_o (next_chain),
        .entry_o      (entry)
    );

    cmcu_addr_xform #(.ADDR_W(ADDR_W), .CHAIN_W(CHAIN_W), .ENTRY_W(ENTRY_W)) xf_i (
        .chain_i (next_chain),
        .entry_i (entry),
        .addr_o  (xf_addr)
    );

    // Counter and chain register: step, load at the end of a chain, or reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q    <= A_HEAD;
            chain_q <= CH_A;
        end else if (cont) begin
            pc_q    <= pc_q + ADDR_W'(1);
        end else begin
            pc_q    <= xf_addr;
            chain_q <= next_chain;
        end
    end

endmodule

// File: rtl/cmcu_seq_chk.sv
// Checker for cmcu_seq_top. It relates the counter, the chain register,
// the inputs and the outputs over time. It is bound to every instance of the top.
module cmcu_seq_chk #(
    parameter int ADDR_W  = cmcu_pkg::ADDR_W,
    parameter int CHAIN_W = cmcu_pkg::CHAIN_W,
    parameter int MO_W    = cmcu_pkg::MO_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               x1,
    input logic               x2,
    input logic [MO_W-1:0]    y,
    input logic [ADDR_W-1:0]  pc,
    input logic [CHAIN_W-1:0] chain,
    input logic               cont
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (pc == 3'd0 && chain == 2'b00));

    // R2
    chain_a_exit_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc == 3'd4) |-> (y == 5'b10010 && !cont));

    // R3
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cont |=> (pc == ADDR_W'($past(pc) + ADDR_W'(1))));

    // R4
    a_to_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc == 3'd4 && x1) |=> (pc == 3'd5 && chain == 2'b01));

    // R5
    a_to_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc == 3'd4 && !x1 && x2) |=> (pc == 3'd7 && chain == 2'b10));

    // R6
    a_reenter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc == 3'd4 && !x1 && !x2) |=> (pc == 3'd3 && chain == 2'b00));

    // R7
    b_to_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc == 3'd6) |=> (pc == 3'd7 && chain == 2'b10));

    // R8
    c_to_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc == 3'd7) |=> (pc == 3'd5 && chain == 2'b01));

    // R9
    chain_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chain == ((pc <= 3'd4) ? 2'b00 : (pc <= 3'd6) ? 2'b01 : 2'b10));

    // R9
    no_bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chain != 2'b11);

endmodule

bind cmcu_seq_top cmcu_seq_chk #(
    .ADDR_W(ADDR_W), .CHAIN_W(CHAIN_W), .MO_W(MO_W)
) chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .x1    (x1),
    .x2    (x2),
    .y     (y),
    .pc    (pc_q),
    .chain (chain_q),
    .cont  (cont)
);

// File: tb/cmcu_seq_top_tb_top.sv
// Bench for cmcu_seq_top. It walks a stored vector table, then runs
// directed reset tests and a flowchart-model sweep of all four condition pairs.
module cmcu_seq_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       x1 = 1'b0;
    logic       x2 = 1'b0;
    logic [4:0] y;
    int         checks = 0;
    int         failures = 0;
    bit         done = 1'b0;

    // 50 MHz clock.
    always #10 clk = ~clk;

    cmcu_seq_top dut_i (
        .clk   (clk),
        .rst_n (rst_n),
        .x1    (x1),
        .x2    (x2),
        .y     (y)
    );

    // Each entry is {x1, x2, expected y after the edge}. The walk starts at 000.
    localparam int NVEC = 12;
    localparam logic [6:0] VEC [NVEC] = '{
        7'b00_00101,  // 001, R3
        7'b00_00011,  // 010, R3
        7'b00_00100,  // 011, R3
        7'b00_10010,  // 100, R2
        7'b00_00100,  // re-enter 011, R6
        7'b00_10010,  // 100
        7'b01_00101,  // to 111, R5
        7'b11_01001,  // to 101 ignoring x, R8 R10
        7'b00_00100,  // 110, R3
        7'b10_00101,  // to 111 ignoring x, R7
        7'b01_01001,  // to 101, R8
        7'b00_00100   // 110
    };

    // Flowchart model: the microoperations shown at each address.
    function automatic logic [4:0] model_y(input int a);
        case (a)
            0: return 5'b00011;
            1: return 5'b00101;
            2: return 5'b00011;
            3: return 5'b00100;
            4: return 5'b10010;
            5: return 5'b01001;
            6: return 5'b00100;
            default: return 5'b00101;
        endcase
    endfunction

    // Flowchart model: the next address.
    function automatic int model_next(input int a, input logic c1, input logic c2);
        case (a)
            4: return c1 ? 5 : (c2 ? 7 : 3);
            6: return 7;
            7: return 5;
            default: return a + 1;
        endcase
    endfunction

    // Compare and record one check.
    task automatic check(input string tag, input logic [4:0] got, input logic [4:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: y=%b expected %b", tag, got, exp);
        end
    endtask

    // Drive the conditions, take one edge, and settle at the falling edge.
    task automatic step(input logic c1, input logic c2);
        x1 = c1;
        x2 = c2;
        @(posedge clk);
        @(negedge clk);
    endtask

    // One synchronous reset edge.
    task automatic do_reset();
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Main sequence.
    initial begin
        @(negedge clk);
        do_reset();
        check("R1 reset state", y, 5'b00011);

        // Stored vector walk.
        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][6], VEC[i][5]);
            check($sformatf("R2 vector %0d", i), y, VEC[i][4:0]);
        end

        // R1: reset in the middle of chain B, with the conditions set, returns to 000.
        x1 = 1'b1;
        x2 = 1'b1;
        do_reset();
        check("R1 reset mid chain", y, 5'b00011);

        // R1: a held reset stays at 000.
        rst_n = 1'b0;
        step(1'b1, 1'b0);
        step(1'b0, 1'b1);
        check("R1 held reset", y, 5'b00011);
        rst_n = 1'b1;

        // R9: after a reset from the B/C loop, the chain register is back to A.
        // Getting there: x1 at address 100 leads into chain B.
        do_reset();
        for (int i = 0; i < 6; i++) step(1'b1, 1'b0);
        do_reset();
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        check("R9 chain A decision after reset", y, 5'b00100);

        // Flowchart-model sweep over the four condition pairs.
        // Each pair is held for many passes.
        for (int c = 0; c < 4; c++) begin
            automatic logic c1 = c[1];
            automatic logic c2 = c[0];
            automatic int   a  = 0;
            automatic string tag = c1 ? "R4" : (c2 ? "R5" : "R6");
            do_reset();
            for (int k = 0; k < 30; k++) begin
                a = model_next(a, c1, c2);
                step(c1, c2);
                check($sformatf("%s x=%0d cycle %0d", tag, c, k), y, model_y(a));
            end
        end

        // R10: toggling the conditions inside chain A changes nothing.
        do_reset();
        step(1'b1, 1'b1);
        check("R10 ignored at 000", y, 5'b00101);
        step(1'b0, 1'b1);
        check("R10 ignored at 001", y, 5'b00011);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: y=%b expected completion", y);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule